// File: doc/BRIEF.md
# Segment Line Latch and Drive Level Selector

This block sits at the output end of a dot-matrix segment driver. A capture stage upstream assembles one display line of pixel bits. When the line clock falls, the whole line is copied into an output latch. The alternation (polarity) input is registered on the same edge, so new data and new polarity always take effect together.

For every output, the block produces a 2-bit level code that selects one of three analog levels: the upper extreme, the lower extreme or the mid level. An active-low display-enable input blanks every output to the mid level. This blanking does not depend on any clock, so it works from the moment power is applied, including while reset is held. A narrow mode is also provided. In that mode only the central 240 outputs carry pixel data, and the outer outputs on each side drive the not-selected level.

The line clock is treated as a slow strobe synchronous to the block clock, and its falling edge is detected in that clock domain. The analog switches and level shifters that follow the level code are outside this block.

Top module: `lcd_seg_level_top`

## Requirements
- R1: After reset the line latch holds all zeros and the registered polarity is 0, so with display enabled every output reads code 10 until the first line load.
- R2: On the first clock edge at which the line clock is seen low after having been seen high, all NUM_OUT bits of line_in are copied into the latch. The outputs reflect the new line from the following cycle.
- R3: alt_in is registered only on that same falling-edge detection. Changing alt_in at any other time has no effect on the outputs.
- R4: While disp_en is low, every output is code 00 (mid), whatever the latch, the polarity, the mode and the reset state. The blanking takes effect in the same cycle, with no clock needed.
- R5: With disp_en high, output i is code 01 (upper extreme) when latched pixel i XOR registered polarity is 1, and code 10 (lower extreme) otherwise.
- R6: With narrow_mode high and disp_en high, outputs with index 0 to 39 and 280 to 319 (outputs 1 to 40 and 281 to 320) drive the not-selected level: code 01 when the registered polarity is 1, code 10 when it is 0. Outputs with index 40 to 279 follow R5.
- R7: Code 11 never appears on any output.
- R8: A rising edge of the line clock, or holding the line clock high, does not load the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_clk | input | 1 | Line strobe; its falling edge loads the latch |
| alt_in | input | 1 | Frame alternation (polarity) input |
| disp_en | input | 1 | Display enable, active high; low forces mid level on all outputs |
| narrow_mode | input | 1 | High selects the 240-output mode |
| line_in | input | NUM_OUT | Captured line from the capture stage; bit i belongs to output i |
| level_out | output | 2*NUM_OUT | Level code of output i at bits [2i+1:2i] |

## Verification
The assertions assume that line_clk, disp_en and narrow_mode are synchronous to clk, and that line_clk stays low while reset is asserted. Under these assumptions, the only output changes not caused by a detected line-clock fall are those caused by a change in disp_en or narrow_mode. The stimulus changes every input only on the falling edge of clk. It holds line_clk low through reset, and each line-clock pulse is at least one full clock cycle high and one full cycle low, so every fall is seen exactly once.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  // Drive level code presented to the analog switch stage
  typedef enum logic [1:0] {
    LVL_MID   = 2'b00,
    LVL_UPPER = 2'b01,
    LVL_LOWER = 2'b10
  } lvl_e;

  localparam int unsigned LVL_W = 2;

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;

endmodule

// File: rtl/lcd_line_latch.sv
module lcd_line_latch #(
  parameter int unsigned NUM_OUT = 320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_clk,
  input  logic               alt_in,
  input  logic [NUM_OUT-1:0] line_in,
  output logic [NUM_OUT-1:0] pix_q,
  output logic               pol_q
);

  logic lc_prev_q;
  logic load_en;

  // Next-state: falling edge of the line strobe seen in the clk domain
  always_comb begin
    load_en = lc_prev_q & ~line_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_prev_q <= 1'b0;
    end else begin
      lc_prev_q <= line_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      pol_q <= 1'b0;
    end else if (load_en) begin
      pix_q <= line_in;
      pol_q <= alt_in;
    end
  end

endmodule

// File: rtl/lcd_level_cell.sv
module lcd_level_cell
  import lcd_seg_pkg::*;
#(
  parameter bit IS_OUTER = 1'b0
) (
  input  logic pixel,
  input  logic pol,
  input  logic disp_en,
  input  logic narrow_mode,
  output lvl_e code
);

  logic eff_pix;

  always_comb begin
    // Outer outputs in narrow mode behave as an unlit pixel
    eff_pix = (IS_OUTER && narrow_mode) ? 1'b0 : pixel;
    if (!disp_en) begin
      code = LVL_MID;
    end else if (eff_pix ^ pol) begin
      code = LVL_UPPER;
    end else begin
      code = LVL_LOWER;
    end
  end

endmodule

// File: rtl/lcd_seg_level_top.sv
module lcd_seg_level_top
  import lcd_seg_pkg::*;
#(
  parameter int unsigned NUM_OUT = 320,
  parameter int unsigned MASK_LO = 40,
  parameter int unsigned MASK_HI = 280
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_clk,
  input  logic                     alt_in,
  input  logic                     disp_en,
  input  logic                     narrow_mode,
  input  logic [NUM_OUT-1:0]       line_in,
  output logic [LVL_W*NUM_OUT-1:0] level_out
);

  logic               rst_sync_n;
  logic [NUM_OUT-1:0] pix_q;
  logic               pol_q;

  lcd_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  lcd_line_latch #(.NUM_OUT(NUM_OUT)) u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .line_clk (line_clk),
    .alt_in   (alt_in),
    .line_in  (line_in),
    .pix_q    (pix_q),
    .pol_q    (pol_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cell
    localparam bit OUTER = (g < MASK_LO) || (g >= MASK_HI);
    lvl_e code;

    lcd_level_cell #(.IS_OUTER(OUTER)) u_cell (
      .pixel       (pix_q[g]),
      .pol         (pol_q),
      .disp_en     (disp_en),
      .narrow_mode (narrow_mode),
      .code        (code)
    );

    assign level_out[LVL_W*g +: LVL_W] = code;
  end

endmodule

// File: rtl/lcd_seg_level_chk.sv
module lcd_seg_level_chk #(
  parameter int unsigned NUM_OUT = 320,
  parameter int unsigned MASK_HI = 280
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 line_clk,
  input logic                 disp_en,
  input logic                 narrow_mode,
  input logic [2*NUM_OUT-1:0] level_out
);

  logic lc_d, fell_q, disp_d, mode_d, valid_q;
  logic any_bad, any_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_d    <= 1'b0;
      fell_q  <= 1'b0;
      disp_d  <= 1'b0;
      mode_d  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      lc_d    <= line_clk;
      fell_q  <= lc_d & ~line_clk;
      disp_d  <= disp_en;
      mode_d  <= narrow_mode;
      valid_q <= 1'b1;
    end
  end

  always_comb begin
    any_bad = 1'b0;
    any_mid = 1'b0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (level_out[2*i +: 2] == 2'b11) any_bad = 1'b1;
      if (level_out[2*i +: 2] == 2'b00) any_mid = 1'b1;
    end
  end

  // R4
  blank_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (level_out == '0));

  // R7
  no_code11_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_bad);

  // R5
  lit_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !any_mid);

  // R6
  outer_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && narrow_mode) |->
      (level_out[1:0] == level_out[2*NUM_OUT-1 -: 2]) &&
      (level_out[1:0] == level_out[2*MASK_HI +: 2]));

  // R2
  hold_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !fell_q && disp_en == disp_d && narrow_mode == mode_d)
      |-> $stable(level_out));

endmodule

bind lcd_seg_level_top lcd_seg_level_chk #(
  .NUM_OUT (NUM_OUT),
  .MASK_HI (MASK_HI)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_clk    (line_clk),
  .disp_en     (disp_en),
  .narrow_mode (narrow_mode),
  .level_out   (level_out)
);

// File: tb/lcd_seg_level_top_bench.sv
module lcd_seg_level_top_bench;

  localparam int N = 320;
  localparam int LO = 40;
  localparam int HI = 280;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           line_clk = 1'b0;
  logic           alt_in = 1'b0;
  logic           disp_en = 1'b0;
  logic           narrow_mode = 1'b0;
  logic [N-1:0]   line_in = '0;
  logic [2*N-1:0] level_out;

  int n_checks = 0;
  int n_fail = 0;
  logic [N-1:0] m_pix = '0;
  logic         m_pol = 1'b0;

  always #4 clk = ~clk;

  lcd_seg_level_top u_lcd_seg_level_top (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .alt_in(alt_in),
    .disp_en(disp_en), .narrow_mode(narrow_mode), .line_in(line_in),
    .level_out(level_out)
  );

  function automatic logic [1:0] exp_code(int i);
    logic p;
    if (!disp_en) return 2'b00;
    p = (narrow_mode && (i < LO || i >= HI)) ? 1'b0 : m_pix[i];
    return (p ^ m_pol) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req);
    int bad_i = -1;
    logic [1:0] e;
    for (int i = N-1; i >= 0; i--) begin
      e = exp_code(i);
      if (level_out[2*i +: 2] !== e) bad_i = i;
    end
    n_checks++;
    if (bad_i >= 0) begin
      n_fail++;
      $display("FAIL %s: output %0d actual %b expected %b", req, bad_i,
               level_out[2*bad_i +: 2], exp_code(bad_i));
    end
  endtask

  function automatic logic [N-1:0] pattern(int seed);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (((i * 7 + seed) >> 2) & 1) != 0;
    return v;
  endfunction

  task automatic pulse_line(logic [N-1:0] d, logic a);
    @(negedge clk);
    line_in = d; alt_in = a; line_clk = 1'b1;
    @(negedge clk);
    line_clk = 1'b0;
    @(negedge clk);
    m_pix = d; m_pol = a;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R4 blank during reset");
    disp_en = 1'b1;
    #1 check("R1 reset latch zero");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");
  endtask

  task automatic t_basic;
    pulse_line(pattern(0), 1'b0);
    check("R2 R5 load pol0");
    pulse_line(pattern(3), 1'b1);
    check("R5 load pol1");
    pulse_line('1, 1'b0);
    check("R5 all ones");
  endtask

  task automatic t_no_load;
    @(negedge clk);
    line_in = pattern(9); alt_in = ~m_pol;
    repeat (3) @(negedge clk);
    check("R2 R3 no fall no change");
    line_clk = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 rise and hold high");
    line_clk = 1'b0;
    @(negedge clk);
    m_pix = line_in; m_pol = alt_in;
    check("R2 R3 fall loads");
    alt_in = ~alt_in;
    repeat (2) @(negedge clk);
    check("R3 alt toggle ignored");
  endtask

  task automatic t_blank;
    @(negedge clk);
    disp_en = 1'b0;
    #1 check("R4 blank immediate");
    pulse_line(pattern(5), 1'b1);
    check("R4 blank with load");
    disp_en = 1'b1;
    #1 check("R4 R5 unblank");
  endtask

  task automatic t_narrow;
    @(negedge clk);
    narrow_mode = 1'b1;
    pulse_line('1, 1'b0);
    check("R6 narrow pol0");
    pulse_line('1, 1'b1);
    check("R6 narrow pol1");
    pulse_line(pattern(11), 1'b0);
    check("R6 R7 narrow pattern");
    narrow_mode = 1'b0;
    #1 check("R6 wide again");
  endtask

  initial begin
    t_reset;
    t_basic;
    t_no_load;
    t_blank;
    t_narrow;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule